// File: doc/BRIEF.md
# Hybrid Pointer/Vector Coherence Directory Set

This block is a single set of a set-associative coherence directory for a chip with `NUM_CORES` cores. A small number of its ways (`NUM_VEC`, the low-numbered ways) keep a full sharer bit-vector. The other ways keep only a tag, a valid bit and one core number, plus a broadcast flag that stands for "every core may hold a copy". Most lines have a single sharer, so most ways can be narrow, and the set costs far less storage than one with a vector in every way.

The caller sends one request per clock, keyed by tag. The request is a lookup, an add-sharer, a remove-sharer or an allocate. One cycle later the block returns a hit flag and a decoded `NUM_CORES`-bit sharer mask, which the caller uses to send invalidations. Allocations that replace a live line also return the victim's tag and mask.

A narrow way may need to record a second sharer. In that case the block moves the line into a vector way, and the line that held that vector way drops into the narrow way. If the displaced line has one sharer, it is kept there as a pointer. If it has two or more, it is marked as shared by all cores. The decoded mask may therefore hold more cores than the exact sharer set, but never fewer.

Top module: `hybrid_dir_set`

## Requirements
- R1: `req_op` encodes 0 = lookup, 1 = add-sharer, 2 = remove-sharer, 3 = allocate. Each accepted request produces `rsp_valid` = 1 in the following cycle. A cycle without a request produces `rsp_valid`, `rsp_hit`, `rsp_evict` and `rsp_mask` all zero in the following cycle.
- R2: A lookup hits when a valid way holds `req_tag`, and returns that line's decoded mask, where bit i stands for core i. A lookup miss returns hit 0 and a zero mask. A lookup changes no sharer state.
- R3: Add-sharer on a hit returns hit 1 and a mask that contains the requester. Add-sharer on a vector way sets the requester's bit. Add-sharer on a pointer way that already names the requester, or that is marked all-sharers, changes nothing. Add-sharer on a miss returns hit 0 and a zero mask and changes nothing.
- R4: When a pointer way must record a second core, the line moves into a vector way holding exactly both cores. The line that held that vector way moves into the freed pointer way.
- R5: The vector way taken on overflow is chosen in this order: the lowest-numbered invalid vector way; otherwise the lowest-numbered vector way with exactly one sharer; otherwise the least recently used vector way.
- R6: A displaced line with one sharer becomes a pointer to that core. A displaced line with two or more sharers becomes all-sharers. A displaced invalid way leaves the pointer way invalid.
- R7: An all-sharers line returns a mask of all ones on every hit. A remove-sharer request leaves it unchanged.
- R8: Remove-sharer clears the requester's bit in a vector way, and the way is invalidated when no bit remains. On a pointer way, remove-sharer invalidates the way when the pointer names the requester and does nothing otherwise. The response mask is the state after the request.
- R9: Allocate on a miss places the line in a way chosen in this order: the lowest-numbered invalid pointer way; otherwise the lowest-numbered invalid vector way; otherwise the least recently used pointer way. The new line holds only the requester. The response is hit 0 with the requester's one-hot mask.
- R10: `rsp_evict` is 1 only when an allocate replaces a valid line. It then comes with that line's tag and decoded mask.
- R11: Allocate on a tag that already hits behaves exactly as add-sharer, with hit 1 and no eviction.
- R12: Every hit and every allocation makes the touched way the most recently used one. On an overflow, the line moved into the vector way becomes the most recent, and the displaced line takes over its former recency rank.
- R13: Every decoded mask is a superset of the exact set of cores that have been added and not removed since the line was allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset, empties the set |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Request kind (see R1) |
| req_tag | input | TAG_W | Line tag |
| req_core | input | $clog2(NUM_CORES) | Requesting core |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_hit | output | 1 | Tag was present |
| rsp_mask | output | NUM_CORES | Decoded sharer mask after the request |
| rsp_evict | output | 1 | Allocate replaced a valid line |
| rsp_evict_tag | output | TAG_W | Tag of the replaced line |
| rsp_evict_mask | output | NUM_CORES | Decoded mask of the replaced line |

## Verification
Assertions check, on every cycle, the response timing and the idle response, the zero mask on misses, that an add or a hitting allocate always includes the requester, the one-hot mask of a fresh allocation, and that eviction appears only on an allocate miss with a non-empty victim mask. The choice of vector way on overflow, the demotion of the displaced line to a pointer or to all-sharers, the allocation order, the recency order and the superset property depend on the history of many requests. Only the bench's scenarios show them, checked against a behavioural model that keeps both the exact sharer sets and the expected conservative encoding.

// File: rtl/hds_pkg.sv
package hds_pkg;
    typedef enum logic [1:0] {
        OP_LOOKUP = 2'd0,
        OP_ADD    = 2'd1,
        OP_REMOVE = 2'd2,
        OP_ALLOC  = 2'd3
    } dir_op_e;
endpackage

// File: rtl/hds_tag_match.sv
module hds_tag_match #(
    parameter int NUM_WAYS = 8,
    parameter int TAG_W    = 12,
    parameter int WAY_W    = 3
) (
    input  logic [NUM_WAYS-1:0]            valid,
    input  logic [NUM_WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]               tag,
    output logic                           hit,
    output logic [WAY_W-1:0]               hit_way
);
    logic [NUM_WAYS-1:0] eq;

    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_cmp
        assign eq[g] = valid[g] && (tags[g] == tag);
    end

    always_comb begin
        hit     = |eq;
        hit_way = '0;
        for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            if (eq[i]) hit_way = WAY_W'(i);
        end
    end
endmodule

// File: rtl/hds_recency.sv
module hds_recency #(
    parameter int NUM_WAYS = 8,
    parameter int WAY_W    = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           touch_en,
    input  logic [WAY_W-1:0]               touch_way,
    input  logic                           swap_en,
    input  logic [WAY_W-1:0]               swap_a,
    input  logic [WAY_W-1:0]               swap_b,
    output logic [NUM_WAYS-1:0][WAY_W-1:0] age
);
    logic [NUM_WAYS-1:0][WAY_W-1:0] age_q, age_d, swapped;

    always_comb begin
        swapped = age_q;
        if (swap_en) begin
            swapped[swap_a] = age_q[swap_b];
            swapped[swap_b] = age_q[swap_a];
        end
        age_d = swapped;
        if (touch_en) begin
            for (int i = 0; i < NUM_WAYS; i++) begin
                if (WAY_W'(i) == touch_way)
                    age_d[i] = '0;
                else if (swapped[i] < swapped[touch_way])
                    age_d[i] = swapped[i] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WAYS; i++) age_q[i] <= WAY_W'(i);
        end else begin
            age_q <= age_d;
        end
    end

    assign age = age_q;
endmodule

// File: rtl/hds_victim.sv
module hds_victim #(
    parameter int NUM_WAYS  = 8,
    parameter int NUM_VEC   = 2,
    parameter int NUM_CORES = 16,
    parameter int WAY_W     = 3
) (
    input  logic [NUM_WAYS-1:0]                valid,
    input  logic [NUM_VEC-1:0][NUM_CORES-1:0]  vec,
    input  logic [NUM_WAYS-1:0][WAY_W-1:0]     age,
    output logic [WAY_W-1:0]                   alloc_way,
    output logic                               alloc_evict,
    output logic [WAY_W-1:0]                   ovf_way
);
    logic             inv_p, inv_v, lite_v;
    logic [WAY_W-1:0] inv_p_way, inv_v_way, lite_way;
    logic [WAY_W-1:0] lru_p_way, lru_v_way, lru_p_age, lru_v_age;

    always_comb begin
        inv_p     = 1'b0;
        inv_p_way = '0;
        for (int i = NUM_WAYS - 1; i >= NUM_VEC; i--) begin
            if (!valid[i]) begin
                inv_p     = 1'b1;
                inv_p_way = WAY_W'(i);
            end
        end

        inv_v     = 1'b0;
        inv_v_way = '0;
        lite_v    = 1'b0;
        lite_way  = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                inv_v     = 1'b1;
                inv_v_way = WAY_W'(i);
            end else if ($countones(vec[i]) <= 1) begin
                lite_v   = 1'b1;
                lite_way = WAY_W'(i);
            end
        end

        lru_p_way = WAY_W'(NUM_VEC);
        lru_p_age = age[NUM_VEC];
        for (int i = NUM_VEC + 1; i < NUM_WAYS; i++) begin
            if (age[i] > lru_p_age) begin
                lru_p_age = age[i];
                lru_p_way = WAY_W'(i);
            end
        end

        lru_v_way = '0;
        lru_v_age = age[0];
        for (int i = 1; i < NUM_VEC; i++) begin
            if (age[i] > lru_v_age) begin
                lru_v_age = age[i];
                lru_v_way = WAY_W'(i);
            end
        end
    end

    assign alloc_way   = inv_p ? inv_p_way : (inv_v ? inv_v_way : lru_p_way);
    assign alloc_evict = !inv_p && !inv_v;
    assign ovf_way     = inv_v ? inv_v_way : (lite_v ? lite_way : lru_v_way);
endmodule

// File: rtl/hybrid_dir_set.sv
module hybrid_dir_set #(
    parameter int NUM_CORES = 16,
    parameter int NUM_WAYS  = 8,
    parameter int NUM_VEC   = 2,
    parameter int TAG_W     = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [1:0]                   req_op,
    input  logic [TAG_W-1:0]             req_tag,
    input  logic [$clog2(NUM_CORES)-1:0] req_core,
    output logic                         rsp_valid,
    output logic                         rsp_hit,
    output logic [NUM_CORES-1:0]         rsp_mask,
    output logic                         rsp_evict,
    output logic [TAG_W-1:0]             rsp_evict_tag,
    output logic [NUM_CORES-1:0]         rsp_evict_mask
);
    import hds_pkg::*;

    localparam int CORE_W  = $clog2(NUM_CORES);
    localparam int WAY_W   = $clog2(NUM_WAYS);
    localparam int NUM_PTR = NUM_WAYS - NUM_VEC;
    localparam int PTR_W   = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1;
    localparam int VEC_W   = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

    typedef struct packed {
        logic [NUM_WAYS-1:0]                valid;
        logic [NUM_WAYS-1:0][TAG_W-1:0]     tag;
        logic [NUM_VEC-1:0][NUM_CORES-1:0]  vec;
        logic [NUM_PTR-1:0][CORE_W-1:0]     ptr;
        logic [NUM_PTR-1:0]                 bcast;
        logic                               rsp_valid;
        logic                               rsp_hit;
        logic [NUM_CORES-1:0]               rsp_mask;
        logic                               rsp_evict;
        logic [TAG_W-1:0]                   rsp_evict_tag;
        logic [NUM_CORES-1:0]               rsp_evict_mask;
    } set_state_t;

    set_state_t s_q, s_d;

    function automatic logic [CORE_W-1:0] first_core(input logic [NUM_CORES-1:0] v);
        first_core = '0;
        for (int i = NUM_CORES - 1; i >= 0; i--) begin
            if (v[i]) first_core = CORE_W'(i);
        end
    endfunction

    dir_op_e op;
    assign op = dir_op_e'(req_op);

    // decoded sharer mask of every way
    logic [NUM_WAYS-1:0][NUM_CORES-1:0] way_mask;
    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_mask
        if (g < NUM_VEC) begin : g_vec
            assign way_mask[g] = s_q.vec[g];
        end else begin : g_ptr
            assign way_mask[g] = s_q.bcast[g-NUM_VEC] ? {NUM_CORES{1'b1}}
                                 : (NUM_CORES'(1) << s_q.ptr[g-NUM_VEC]);
        end
    end

    logic             hit;
    logic [WAY_W-1:0] hit_way;

    hds_tag_match #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
        .valid   (s_q.valid),
        .tags    (s_q.tag),
        .tag     (req_tag),
        .hit     (hit),
        .hit_way (hit_way)
    );

    logic                           touch_en, swap_en;
    logic [WAY_W-1:0]               touch_way, swap_a, swap_b;
    logic [NUM_WAYS-1:0][WAY_W-1:0] age;

    hds_recency #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_recency (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (touch_en),
        .touch_way (touch_way),
        .swap_en   (swap_en),
        .swap_a    (swap_a),
        .swap_b    (swap_b),
        .age       (age)
    );

    logic [WAY_W-1:0] alloc_way, ovf_way;
    logic             alloc_evict;

    hds_victim #(.NUM_WAYS(NUM_WAYS), .NUM_VEC(NUM_VEC), .NUM_CORES(NUM_CORES), .WAY_W(WAY_W)) u_victim (
        .valid       (s_q.valid),
        .vec         (s_q.vec),
        .age         (age),
        .alloc_way   (alloc_way),
        .alloc_evict (alloc_evict),
        .ovf_way     (ovf_way)
    );

    logic                 hit_is_vec, alloc_is_vec;
    logic [VEC_W-1:0]     hit_v, ovf_v, alloc_v;
    logic [PTR_W-1:0]     hit_p, alloc_p;
    logic [NUM_CORES-1:0] core_bit;

    assign hit_is_vec   = hit_way < WAY_W'(NUM_VEC);
    assign alloc_is_vec = alloc_way < WAY_W'(NUM_VEC);
    assign hit_v        = hit_way[VEC_W-1:0];
    assign ovf_v        = ovf_way[VEC_W-1:0];
    assign alloc_v      = alloc_way[VEC_W-1:0];
    assign hit_p        = PTR_W'(hit_way - WAY_W'(NUM_VEC));
    assign alloc_p      = PTR_W'(alloc_way - WAY_W'(NUM_VEC));
    assign core_bit     = NUM_CORES'(1) << req_core;

    always_comb begin
        s_d                = s_q;
        s_d.rsp_valid      = req_valid;
        s_d.rsp_hit        = 1'b0;
        s_d.rsp_mask       = '0;
        s_d.rsp_evict      = 1'b0;
        s_d.rsp_evict_tag  = '0;
        s_d.rsp_evict_mask = '0;
        touch_en  = 1'b0;
        touch_way = hit_way;
        swap_en   = 1'b0;
        swap_a    = ovf_way;
        swap_b    = hit_way;

        if (req_valid) begin
            unique case (op)
                OP_LOOKUP: begin
                    if (hit) begin
                        s_d.rsp_hit  = 1'b1;
                        s_d.rsp_mask = way_mask[hit_way];
                        touch_en     = 1'b1;
                    end
                end
                OP_ADD, OP_ALLOC: begin
                    if (hit) begin
                        s_d.rsp_hit = 1'b1;
                        touch_en    = 1'b1;
                        if (hit_is_vec) begin
                            s_d.vec[hit_v] = s_q.vec[hit_v] | core_bit;
                            s_d.rsp_mask   = s_d.vec[hit_v];
                        end else if (s_q.bcast[hit_p] || (s_q.ptr[hit_p] == req_core)) begin
                            s_d.rsp_mask = way_mask[hit_way];
                        end else begin
                            // pointer overflow: trade places with a vector way
                            s_d.valid[ovf_way]   = 1'b1;
                            s_d.tag[ovf_way]     = s_q.tag[hit_way];
                            s_d.vec[ovf_v]       = core_bit | way_mask[hit_way];
                            s_d.valid[hit_way]   = s_q.valid[ovf_way];
                            s_d.tag[hit_way]     = s_q.tag[ovf_way];
                            s_d.ptr[hit_p]       = first_core(s_q.vec[ovf_v]);
                            s_d.bcast[hit_p]     = s_q.valid[ovf_way] &&
                                                   ($countones(s_q.vec[ovf_v]) != 1);
                            s_d.rsp_mask         = core_bit | way_mask[hit_way];
                            swap_en              = 1'b1;
                            touch_way            = ovf_way;
                        end
                    end else if (op == OP_ALLOC) begin
                        s_d.rsp_evict = alloc_evict;
                        if (alloc_evict) begin
                            s_d.rsp_evict_tag  = s_q.tag[alloc_way];
                            s_d.rsp_evict_mask = way_mask[alloc_way];
                        end
                        s_d.valid[alloc_way] = 1'b1;
                        s_d.tag[alloc_way]   = req_tag;
                        if (alloc_is_vec) begin
                            s_d.vec[alloc_v] = core_bit;
                        end else begin
                            s_d.ptr[alloc_p]   = req_core;
                            s_d.bcast[alloc_p] = 1'b0;
                        end
                        s_d.rsp_mask = core_bit;
                        touch_en     = 1'b1;
                        touch_way    = alloc_way;
                    end
                end
                OP_REMOVE: begin
                    if (hit) begin
                        s_d.rsp_hit = 1'b1;
                        touch_en    = 1'b1;
                        if (hit_is_vec) begin
                            s_d.vec[hit_v]     = s_q.vec[hit_v] & ~core_bit;
                            s_d.valid[hit_way] = |s_d.vec[hit_v];
                            s_d.rsp_mask       = s_d.vec[hit_v];
                        end else if (s_q.bcast[hit_p]) begin
                            s_d.rsp_mask = way_mask[hit_way];
                        end else if (s_q.ptr[hit_p] == req_core) begin
                            s_d.valid[hit_way] = 1'b0;
                            s_d.rsp_mask       = '0;
                        end else begin
                            s_d.rsp_mask = way_mask[hit_way];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid      = s_q.rsp_valid;
    assign rsp_hit        = s_q.rsp_hit;
    assign rsp_mask       = s_q.rsp_mask;
    assign rsp_evict      = s_q.rsp_evict;
    assign rsp_evict_tag  = s_q.rsp_evict_tag;
    assign rsp_evict_mask = s_q.rsp_evict_mask;
endmodule

// File: rtl/hds_checker.sv
module hds_checker #(
    parameter int NUM_CORES = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         req_valid,
    input logic [1:0]                   req_op,
    input logic [$clog2(NUM_CORES)-1:0] req_core,
    input logic                         rsp_valid,
    input logic                         rsp_hit,
    input logic [NUM_CORES-1:0]         rsp_mask,
    input logic                         rsp_evict,
    input logic [NUM_CORES-1:0]         rsp_evict_mask
);
    assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_evict && rsp_mask == '0));

    assert_miss_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit && $past(req_op) != 2'd3) |-> rsp_mask == '0);

    assert_add_has_core_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && ($past(req_op) == 2'd1 || $past(req_op) == 2'd3))
        |-> rsp_mask[$past(req_core)]);

    assert_alloc_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit && $past(req_op) == 2'd3)
        |-> rsp_mask == (NUM_CORES'(1) << $past(req_core)));

    assert_evict_on_alloc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_evict |-> (rsp_valid && !rsp_hit && $past(req_op) == 2'd3 && rsp_evict_mask != '0));
endmodule

bind hybrid_dir_set hds_checker #(.NUM_CORES(NUM_CORES)) u_hds_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_op         (req_op),
    .req_core       (req_core),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_mask       (rsp_mask),
    .rsp_evict      (rsp_evict),
    .rsp_evict_mask (rsp_evict_mask)
);

// File: tb/hybrid_dir_set_test.sv
module hybrid_dir_set_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [11:0] req_tag = '0;
    logic [3:0]  req_core = '0;
    logic        rsp_valid, rsp_hit, rsp_evict;
    logic [15:0] rsp_mask, rsp_evict_mask;
    logic [11:0] rsp_evict_tag;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    hybrid_dir_set uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_tag(req_tag), .req_core(req_core), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_mask(rsp_mask), .rsp_evict(rsp_evict),
        .rsp_evict_tag(rsp_evict_tag), .rsp_evict_mask(rsp_evict_mask)
    );

    // behavioural reference: 2 vector ways (0,1), 6 pointer ways (2..7)
    bit          mval [8];
    int          mtag [8];
    logic [15:0] mvec [2];
    int          mptr [8];
    bit          mbc  [8];
    int          order [$];      // front = most recent
    logic [15:0] exact [int];    // exact sharer sets per tag

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic int mfind(input int tag);
        for (int w = 0; w < 8; w++) if (mval[w] && mtag[w] == tag) return w;
        return -1;
    endfunction

    function automatic logic [15:0] mmask(input int w);
        if (w < 2) return mvec[w];
        if (mbc[w]) return 16'hFFFF;
        return 16'h1 << mptr[w];
    endfunction

    function automatic int pos_of(input int w);
        foreach (order[i]) if (order[i] == w) return i;
        return -1;
    endfunction

    function automatic void touch(input int w);
        order.delete(pos_of(w));
        order.push_front(w);
    endfunction

    function automatic int oldest(input int lo, input int hi);
        for (int i = order.size() - 1; i >= 0; i--)
            if (order[i] >= lo && order[i] <= hi) return order[i];
        return lo;
    endfunction

    task automatic issue(input int op, input int tag, input int core);
        bit ehit = 0, eev = 0;
        logic [15:0] emask = '0, evm = '0, exs;
        int evt = 0;
        string rq = "R2";
        int w = mfind(tag);
        logic [15:0] cb = 16'h1 << core;

        if (op == 0) begin
            if (w >= 0) begin
                ehit = 1; emask = mmask(w); touch(w);
                if (w >= 2 && mbc[w]) rq = "R7";
            end
        end else if (op == 1 || op == 3) begin
            rq = (op == 3) ? "R11" : "R3";
            if (w >= 0) begin
                ehit = 1;
                if (w < 2) begin
                    mvec[w] |= cb; emask = mvec[w]; touch(w);
                end else if (mbc[w] || mptr[w] == core) begin
                    emask = mmask(w); touch(w);
                end else begin
                    int v = -1, pa, pb, tmp;
                    bit dval; int dtag; logic [15:0] dvec;
                    rq = "R4,R5,R6,R12";
                    for (int i = 1; i >= 0; i--) if (!mval[i]) v = i;
                    if (v < 0) for (int i = 1; i >= 0; i--) if ($countones(mvec[i]) <= 1) v = i;
                    if (v < 0) v = oldest(0, 1);
                    dval = mval[v]; dtag = mtag[v]; dvec = mvec[v];
                    mval[v] = 1; mtag[v] = mtag[w]; mvec[v] = cb | (16'h1 << mptr[w]);
                    mval[w] = dval; mtag[w] = dtag;
                    mbc[w] = 0; mptr[w] = 0;
                    if (dval && $countones(dvec) == 1) begin
                        for (int i = 0; i < 16; i++) if (dvec[i]) mptr[w] = i;
                    end else if (dval) mbc[w] = 1;
                    pa = pos_of(v); pb = pos_of(w);
                    tmp = order[pa]; order[pa] = order[pb]; order[pb] = tmp;
                    touch(v);
                    emask = mvec[v];
                end
                exact[tag] = exact[tag] | cb;
            end else if (op == 3) begin
                int a = -1;
                rq = "R9,R10";
                for (int i = 7; i >= 2; i--) if (!mval[i]) a = i;
                if (a < 0) for (int i = 1; i >= 0; i--) if (!mval[i]) a = i;
                if (a < 0) begin
                    a = oldest(2, 7);
                    eev = 1; evt = mtag[a]; evm = mmask(a);
                    exact.delete(evt);
                end
                mval[a] = 1; mtag[a] = tag;
                if (a < 2) mvec[a] = cb; else begin mptr[a] = core; mbc[a] = 0; end
                touch(a);
                emask = cb;
                exact[tag] = cb;
            end
        end else begin
            rq = "R8";
            if (w >= 0) begin
                ehit = 1; touch(w);
                if (w < 2) begin
                    mvec[w] &= ~cb;
                    if (mvec[w] == 0) mval[w] = 0;
                    emask = mvec[w];
                end else if (mbc[w]) begin
                    rq = "R7"; emask = 16'hFFFF;
                end else if (mptr[w] == core) begin
                    mval[w] = 0; emask = 0;
                end else emask = mmask(w);
                exact[tag] = exact[tag] & ~cb;
                if (!mval[w]) exact.delete(tag);
            end
        end
        exs = exact.exists(tag) ? exact[tag] : 16'h0;

        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_tag = 12'(tag); req_core = 4'(core);
        @(posedge clk);
        #1;
        chk(rsp_valid == 1'b1, "R1", "rsp_valid", 32'(rsp_valid), 32'd1);
        chk(rsp_hit == ehit, rq, "rsp_hit", 32'(rsp_hit), 32'(ehit));
        chk(rsp_mask == emask, rq, "rsp_mask", 32'(rsp_mask), 32'(emask));
        chk(rsp_evict == eev, "R10", "rsp_evict", 32'(rsp_evict), 32'(eev));
        if (eev) begin
            chk(rsp_evict_tag == 12'(evt), "R10", "evict_tag", 32'(rsp_evict_tag), 32'(evt));
            chk(rsp_evict_mask == evm, "R10", "evict_mask", 32'(rsp_evict_mask), 32'(evm));
        end
        chk((rsp_mask & exs) == exs, "R13", "superset", 32'(rsp_mask), 32'(exs));
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        #1;
        chk(!rsp_valid && !rsp_hit && !rsp_evict && rsp_mask == 0, "R1", "idle response",
            {rsp_valid, rsp_hit, rsp_evict, 13'd0, rsp_mask}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin mval[i] = 0; mptr[i] = 0; mbc[i] = 0; order.push_back(i); end
        mvec[0] = 0; mvec[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(!rsp_valid && !rsp_hit && !rsp_evict, "R1", "reset state",
            {29'd0, rsp_valid, rsp_hit, rsp_evict}, 32'd0);

        issue(0, 'h005, 1);                          // R2 miss on empty set
        issue(1, 'h005, 1);                          // R3 add on miss
        for (int t = 0; t < 6; t++) issue(3, 'h10 + t, t); // R9 fill pointer ways
        issue(0, 'h10, 0);                           // R2
        issue(1, 'h10, 0);                           // R3 same core, no change
        issue(1, 'h10, 3);                           // R4 overflow into invalid vector way
        issue(3, 'h16, 7);                           // R9 freed pointer way
        issue(1, 'h11, 9);                           // R4 second vector way
        issue(3, 'h17, 2);                           // R9
        issue(1, 'h12, 4);                           // R5 LRU vector, R6 demote to all-sharers
        issue(0, 'h10, 6);                           // R7 all ones
        issue(2, 'h10, 0);                           // R7 remove ignored
        issue(0, 'h10, 0);                           // R7
        issue(2, 'h11, 9);                           // R8 vector down to one sharer
        issue(1, 'h13, 8);                           // R5 single-sharer vector chosen, R6 pointer
        issue(0, 'h11, 0);                           // R6 pointer to core 1
        issue(2, 'h11, 5);                           // R8 other core, unchanged
        issue(2, 'h11, 1);                           // R8 invalidate pointer
        issue(0, 'h11, 1);                           // R8 now misses
        idle();
        issue(3, 'h20, 6);                           // R9 invalid pointer way
        issue(3, 'h21, 5);                           // R10 eviction of LRU pointer way
        issue(3, 'h20, 11);                          // R11 allocate on hit
        issue(2, 'h12, 2);                           // R8
        issue(2, 'h12, 4);                           // R8
        issue(2, 'h13, 3);
        issue(2, 'h13, 8);
        issue(2, 'h20, 11);
        issue(2, 'h20, 6);
        issue(3, 'h22, 13);                          // R9 invalid vector way when pointers full
        issue(1, 'h22, 14);                          // R3 vector add
        idle();
        // R12 and R13 under a mixed stream
        for (int n = 0; n < 600; n++) begin
            if ($urandom_range(0, 9) == 0) idle();
            else issue(int'($urandom_range(0, 3)), 'h30 + int'($urandom_range(0, 11)),
                       int'($urandom_range(0, 15)));
        end
        idle();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule